// File: doc/BRIEF.md
# Hub Pointer Load and Indexed Addressing Unit

This block is the pointer datapath of a small processor core. It keeps two hub byte-address pointers, A and B, each 18 bits wide. A pointer-load operation writes one pointer from a 16-bit field that counts longs. The field is widened to a byte address by placing two zero bits below it. The widened value is used as is in absolute mode. In PC-relative mode it is added to the program counter, which is also given as a long count and widened the same way.

An indexed access picks one pointer and adds a signed six-bit index scaled by the element size. This lets one pointer value reach any entry of a 64-entry table of bytes, words or longs. The access can also write the sum back into the pointer, either before the access (pre-modify) or after it (post-modify). Walking an array upward or downward is then a matter of the index sign. The effective address is a combinational output in the same cycle as the access request. Pointer writes take effect on the next clock edge.

Top module: `hub_ptr_unit`

## Requirements
- R1: While `rstN` is low, and after its release until the first write, both pointers read zero.
- R2: A load with `loadEn` high writes only the pointer named by `loadSel` (0 = A, 1 = B). The other pointer keeps its value unless an access modifies it.
- R3: With `loadRel` = 0 the selected pointer becomes `{loadField, 2'b00}` after the next rising clock edge.
- R4: With `loadRel` = 1 the selected pointer becomes `{loadField, 2'b00} + {pcLong, 2'b00}`, truncated to 18 bits.
- R5: `accIdx` is a two's-complement index from -32 to +31. The scale comes from `accSize`: 0 gives 1 (byte), 1 gives 2 (word), and 2 or 3 give 4 (long). When `accEn` is high and `accMode` is not 2, `effAddr` equals the pointer named by `accSel` (0 = A, 1 = B) plus index times scale, modulo 2^18, in the same cycle.
- R6: With `accMode` 0 or 3 (no modify), an access leaves both pointers unchanged.
- R7: With `accMode` = 1 (pre-modify), the selected pointer becomes the same value as `effAddr` at the next edge.
- R8: With `accMode` = 2 (post-modify), `effAddr` equals the selected pointer's current value, and the pointer then becomes pointer plus index times scale.
- R9: When a load and a modifying access name the same pointer in one cycle, the load value is written and the modify is dropped. `effAddr` still comes from the old pointer value.
- R10: A load on one pointer and a modifying access on the other in the same cycle both take effect.
- R11: All address sums wrap modulo 2^18. Examples: a pre-decrement below zero, and a PC-relative load past the top of the hub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Pointer-load request |
| loadSel | input | 1 | Load target: 0 = A, 1 = B |
| loadRel | input | 1 | 0 = absolute, 1 = PC-relative |
| loadField | input | 16 | Long-granular address or offset |
| pcLong | input | 16 | Program counter as a long count |
| accEn | input | 1 | Indexed-access request |
| accSel | input | 1 | Access pointer: 0 = A, 1 = B |
| accIdx | input | 6 | Signed element index |
| accSize | input | 2 | Element size code |
| accMode | input | 2 | 0 none, 1 pre-modify, 2 post-modify, 3 none |
| effAddr | output | 18 | Effective byte address |
| ptrA | output | 18 | Pointer A |
| ptrB | output | 18 | Pointer B |

## Verification
Directed cases cover the extremes:
- the largest absolute field;
- a PC-relative sum that crosses the top of the 18-bit space;
- a long-scaled index of -32 from pointer zero, which must wrap downward;
- a load and a modify on the same pointer in one cycle, and then on different pointers.

Randomized cycles then mix all size codes, all four modify codes, both pointers and random loads. Each cycle's effective address and next pointer values are compared with a bench model. This separates a wrong scale or a missing sign extension (bad `effAddr`) from a wrong pre/post choice (right address, wrong write-back) and from a wrong priority (wrong pointer after a collision).

// File: rtl/hub_ptr_pkg.sv
package hub_ptr_pkg;
  localparam int NUM_PTR = 2;

  typedef enum logic [1:0] {
    MOD_NONE = 2'b00,
    MOD_PRE  = 2'b01,
    MOD_POST = 2'b10,
    MOD_RSVD = 2'b11
  } modKind_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_LONGX = 2'b11
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PTR-1:0] wrEn;    // pointer i is written this edge
    logic [NUM_PTR-1:0] wrLoad;  // write source: 1 = load value, 0 = index sum
    logic               effSum;  // effective address uses pointer + scaled index
    logic [1:0]         shamt;   // index scale as left shift
  } ptrStrobe_t;
endpackage

// File: rtl/hub_ptr_ctrl.sv
module hub_ptr_ctrl
  import hub_ptr_pkg::*;
(
  input  logic       loadEn,
  input  logic       loadSel,
  input  logic       accEn,
  input  logic       accSel,
  input  logic [1:0] accSize,
  input  logic [1:0] accMode,
  output ptrStrobe_t strobe
);
  logic isModify;
  logic [NUM_PTR-1:0] loadHit;
  logic [NUM_PTR-1:0] modHit;

  always_comb begin
    isModify = accEn && ((modKind_e'(accMode) == MOD_PRE) || (modKind_e'(accMode) == MOD_POST));
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_hit
    assign loadHit[i] = loadEn && (loadSel == 1'(i));
    assign modHit[i]  = isModify && (accSel == 1'(i));
  end

  always_comb begin
    strobe.wrEn   = loadHit | modHit;
    strobe.wrLoad = loadHit;            // load wins over modify on the same pointer
    strobe.effSum = (modKind_e'(accMode) != MOD_POST);
    unique case (elemSize_e'(accSize))
      SZ_BYTE: strobe.shamt = 2'd0;
      SZ_WORD: strobe.shamt = 2'd1;
      default: strobe.shamt = 2'd2;
    endcase
  end
endmodule

// File: rtl/hub_ptr_dp.sv
module hub_ptr_dp
  import hub_ptr_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int FIELD_W = 16,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptrStrobe_t         strobe,
  input  logic               loadRel,
  input  logic [FIELD_W-1:0] loadField,
  input  logic [FIELD_W-1:0] pcLong,
  input  logic               accSel,
  input  logic [IDX_W-1:0]   accIdx,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  ptrA,
  output logic [ADDR_W-1:0]  ptrB
);
  localparam int PAD_W = ADDR_W - FIELD_W;
  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [ADDR_W-1:0] loadWide, pcWide, loadVal;
  logic [ADDR_W-1:0] idxExt, idxScaled, basePtr, idxSum;

  always_comb begin
    loadWide  = {loadField, {PAD_W{1'b0}}};
    pcWide    = {pcLong, {PAD_W{1'b0}}};
    loadVal   = loadRel ? (loadWide + pcWide) : loadWide;
    idxExt    = {{EXT_W{accIdx[IDX_W-1]}}, accIdx};
    idxScaled = idxExt << strobe.shamt;
    basePtr   = ptrQ[accSel];
    idxSum    = basePtr + idxScaled;
    effAddr   = strobe.effSum ? idxSum : basePtr;
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ[i] <= '0;
      else if (strobe.wrEn[i])
        ptrQ[i] <= strobe.wrLoad[i] ? loadVal : idxSum;
    end
  end

  assign ptrA = ptrQ[0];
  assign ptrB = ptrQ[1];
endmodule

// File: rtl/hub_ptr_unit.sv
module hub_ptr_unit
  import hub_ptr_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int FIELD_W = 16,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic               loadRel,
  input  logic [FIELD_W-1:0] loadField,
  input  logic [FIELD_W-1:0] pcLong,
  input  logic               accEn,
  input  logic               accSel,
  input  logic [IDX_W-1:0]   accIdx,
  input  logic [1:0]         accSize,
  input  logic [1:0]         accMode,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  ptrA,
  output logic [ADDR_W-1:0]  ptrB
);
  ptrStrobe_t strobe;

  hub_ptr_ctrl u_ctrl (
    .loadEn (loadEn),
    .loadSel(loadSel),
    .accEn  (accEn),
    .accSel (accSel),
    .accSize(accSize),
    .accMode(accMode),
    .strobe (strobe)
  );

  hub_ptr_dp #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadRel  (loadRel),
    .loadField(loadField),
    .pcLong   (pcLong),
    .accSel   (accSel),
    .accIdx   (accIdx),
    .effAddr  (effAddr),
    .ptrA     (ptrA),
    .ptrB     (ptrB)
  );
endmodule

// File: rtl/hub_ptr_unit_chk.sv
module hub_ptr_unit_chk #(
  parameter int ADDR_W  = 18,
  parameter int FIELD_W = 16,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadEn,
  input logic               loadSel,
  input logic               loadRel,
  input logic [FIELD_W-1:0] loadField,
  input logic [FIELD_W-1:0] pcLong,
  input logic               accEn,
  input logic               accSel,
  input logic [IDX_W-1:0]   accIdx,
  input logic [1:0]         accSize,
  input logic [1:0]         accMode,
  input logic [ADDR_W-1:0]  effAddr,
  input logic [ADDR_W-1:0]  ptrA,
  input logic [ADDR_W-1:0]  ptrB
);
  localparam int PAD_W = ADDR_W - FIELD_W;

  logic accOnA, touchB;
  assign accOnA = accEn && !accSel;
  assign touchB = (loadEn && loadSel) || (accEn && accSel && (accMode == 2'b01 || accMode == 2'b10));

  assert_abs_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !loadSel && !loadRel) |=> (ptrA == {$past(loadField), {PAD_W{1'b0}}}));

  assert_rel_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && loadSel && loadRel) |=>
      (ptrB == ADDR_W'({$past(loadField), {PAD_W{1'b0}}} + {$past(pcLong), {PAD_W{1'b0}}})));

  assert_other_untouched_R2: assert property (@(posedge clk) disable iff (!rstN)
    !touchB |=> (ptrB == $past(ptrB)));

  assert_no_modify_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accOnA && !loadEn && (accMode == 2'b00 || accMode == 2'b11)) |=> (ptrA == $past(ptrA)));

  assert_post_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accOnA && accMode == 2'b10) |-> (effAddr == ptrA));

  assert_pre_writeback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accOnA && accMode == 2'b01 && !(loadEn && !loadSel)) |=> (ptrA == $past(effAddr)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !loadSel && !loadRel && accOnA) |=> (ptrA == {$past(loadField), {PAD_W{1'b0}}}));
endmodule

bind hub_ptr_unit hub_ptr_unit_chk #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel), .loadRel(loadRel),
  .loadField(loadField), .pcLong(pcLong), .accEn(accEn), .accSel(accSel),
  .accIdx(accIdx), .accSize(accSize), .accMode(accMode),
  .effAddr(effAddr), .ptrA(ptrA), .ptrB(ptrB)
);

// File: tb/hub_ptr_unit_tb.sv
`timescale 1ns/1ps
module hub_ptr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 0, loadSel = 0, loadRel = 0;
  logic [15:0] loadField = '0, pcLong = '0;
  logic        accEn = 0, accSel = 0;
  logic [5:0]  accIdx = '0;
  logic [1:0]  accSize = '0, accMode = '0;
  logic [17:0] effAddr, ptrA, ptrB;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [17:0] mA = '0, mB = '0;
  string tagA = "R1", tagB = "R1";

  always #2.5 clk = ~clk;

  hub_ptr_unit u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel), .loadRel(loadRel),
    .loadField(loadField), .pcLong(pcLong), .accEn(accEn), .accSel(accSel),
    .accIdx(accIdx), .accSize(accSize), .accMode(accMode),
    .effAddr(effAddr), .ptrA(ptrA), .ptrB(ptrB)
  );

  function automatic logic [17:0] scaledIdx(logic [5:0] idx, logic [1:0] sz);
    int scale = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int v = $signed(idx) * scale;
    return 18'(v);
  endfunction

  function automatic logic [17:0] loadValue(logic rel, logic [15:0] f, logic [15:0] p);
    int unsigned v = f * 4;
    if (rel) v = v + p * 4;
    return 18'(v);
  endfunction

  task automatic chk(string req, logic [17:0] got, logic [17:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkPtrs();
    chk({tagA, " ptrA"}, ptrA, mA);
    chk({tagB, " ptrB"}, ptrB, mB);
  endtask

  task automatic step(logic le, logic ls, logic lr, logic [15:0] lf, logic [15:0] pc,
                      logic ae, logic as, logic [5:0] ai, logic [1:0] asz, logic [1:0] am);
    logic [17:0] base, sum, expEff, nA, nB;
    logic modify;
    @(negedge clk);
    checkPtrs();
    loadEn = le; loadSel = ls; loadRel = lr; loadField = lf; pcLong = pc;
    accEn = ae; accSel = as; accIdx = ai; accSize = asz; accMode = am;
    #1;
    base = as ? mB : mA;
    sum = base + scaledIdx(ai, asz);
    expEff = (am == 2'd2) ? base : sum;
    if (ae) chk((am == 2'd2) ? "R8 effAddr" : (am == 2'd1) ? "R7 effAddr" : "R5 effAddr", effAddr, expEff);
    modify = ae && (am == 2'd1 || am == 2'd2);
    nA = mA; nB = mB; tagA = "R6"; tagB = "R6";
    if (modify && !as) begin nA = sum; tagA = (am == 2'd1) ? "R7" : "R8"; end
    if (modify && as)  begin nB = sum; tagB = (am == 2'd1) ? "R7" : "R8"; end
    if (le && !ls) begin
      nA = loadValue(lr, lf, pc);
      tagA = (modify && !as) ? "R9" : (modify ? "R10" : (lr ? "R4" : "R3"));
    end
    if (le && ls) begin
      nB = loadValue(lr, lf, pc);
      tagB = (modify && as) ? "R9" : (modify ? "R10" : (lr ? "R4" : "R3"));
    end
    if (le && !modify) begin
      if (ls) tagA = "R2"; else tagB = "R2";
    end
    mA = nA; mB = nB;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    tagA = "R1"; tagB = "R1";
    checkPtrs();                     // R1 during reset
    rstN = 1'b1;
    // R3 absolute load, largest field; R2 B untouched
    step(1, 0, 0, 16'hFFFF, 16'h0000, 0, 0, 6'd0, 2'd0, 2'd0);
    // R4 + R11 relative load wrapping past top
    step(1, 1, 1, 16'h0002, 16'hFFFF, 0, 0, 6'd0, 2'd0, 2'd0);
    // R3 load A = 0, then R11 long pre-decrement by 32 wraps below zero
    step(1, 0, 0, 16'h0000, 16'h0000, 0, 0, 6'd0, 2'd0, 2'd0);
    step(0, 0, 0, 16'h0000, 16'h0000, 1, 0, 6'b100000, 2'd2, 2'd1);
    // R8 post-increment by word 31, R6 no modify with max index
    step(0, 0, 0, 16'h0000, 16'h0000, 1, 1, 6'd31, 2'd1, 2'd2);
    step(0, 0, 0, 16'h0000, 16'h0000, 1, 0, 6'd31, 2'd3, 2'd3);
    // R9 load and modify same pointer
    step(1, 0, 0, 16'h1234, 16'h0000, 1, 0, 6'd5, 2'd2, 2'd1);
    // R10 load A and modify B together
    step(1, 0, 1, 16'h0010, 16'h0100, 1, 1, 6'b111111, 2'd0, 2'd2);
    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) == 0, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
           ($urandom % 4) != 0, 1'($urandom), 6'($urandom), 2'($urandom), 2'($urandom));
    end
    step(0, 0, 0, 16'h0, 16'h0, 0, 0, 6'd0, 2'd0, 2'd0);
    @(negedge clk);
    checkPtrs();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule